// File: doc/BRIEF.md
# Configurable UART Frame Transmitter

This block turns one parallel character into an asynchronous serial frame on a single output line. A baud tick at sixteen times the bit rate drives it. A load strobe hands it a data byte, and a small configuration word sets the format of the frame. That word selects a character length of 5 to 8 bits, one or more stop bits, whether a parity bit is sent, and whether that parity is odd or even.

Each frame is a low start bit, then the character bits with the least significant first, then the optional parity bit, then the high stop periods. With the extended-stop setting, a 5-bit character ends with one and a half stop bits and the longer characters end with two. The data byte and the configuration are taken in at the start of each frame. A `busy` output covers the whole frame and a `ready` output shows when a new byte can be loaded.

Top module: `uart_frame_tx`

## Requirements
- R1: Out of reset and between frames, `txd` is 1, `busy` is 0 and `ready` is 1.
- R2: A `load` pulse seen while idle starts a frame. From the next clock `busy` is 1, `ready` is 0 and `txd` is 0 for the start bit.
- R3: Every full bit period lasts exactly 16 `baud_tick` pulses, and `txd` changes only on a clock edge where `baud_tick` is high.
- R4: The character bits follow the start bit, least significant first. `len_sel` 00, 01, 10 and 11 gives 5, 6, 7 and 8 bits. Start, parity and stop bits are not part of this count.
- R5: Bits of `tx_data` above the selected length are never sent and do not affect parity.
- R6: With `par_en`=1, one parity bit follows the last character bit. With `par_even`=0 the character plus parity holds an odd number of ones, and with `par_even`=1 an even number.
- R7: With `par_en`=0, the first stop bit follows the last character bit directly.
- R8: With `stop_ext`=0, one high stop period of 16 ticks ends the frame.
- R9: With `stop_ext`=1 and `len_sel`=00, the stop level lasts 24 ticks (1.5 bits).
- R10: With `stop_ext`=1 and `len_sel` other than 00, the stop level lasts 32 ticks (2 bits).
- R11: The configuration inputs and `tx_data` are captured on the clock that accepts `load`. Changes to them during a frame have no effect on that frame.
- R12: A `load` pulse while `busy` is 1 is ignored. The frame in progress is unchanged.
- R13: `busy` stays 1 until the clock edge that consumes the last tick of the final stop period. On the next clock `busy` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| baud_tick | input | 1 | One-clock pulse at 16x the bit rate |
| load | input | 1 | Strobe that offers `tx_data` for transmission |
| tx_data | input | 8 | Character to send, LSB first |
| len_sel | input | 2 | Character length: 00=5, 01=6, 10=7, 11=8 bits |
| stop_ext | input | 1 | 0: one stop bit; 1: 1.5 stop bits (5-bit) or 2 stop bits (longer) |
| par_en | input | 1 | 1 inserts a parity bit |
| par_even | input | 1 | 0: odd total of ones; 1: even total |
| txd | output | 1 | Serial line, idles high |
| busy | output | 1 | High for the whole frame |
| ready | output | 1 | High when a new `load` will be accepted |

## Verification
The properties assume that `baud_tick` is a single-cycle pulse and never arrives on two clocks in a row. They also assume the reset release is given the two clocks it needs to pass the internal synchronizer before any `load` arrives. The bench produces ticks on one clock in three and waits after reset before its first load. During frames it changes `tx_data`, the configuration fields and `load` at random. The properties only watch the line and `busy` around those inputs, so they do not depend on the inputs staying quiet.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

  typedef enum logic [2:0] {
    TX_IDLE  = 3'd0,
    TX_START = 3'd1,
    TX_DATA  = 3'd2,
    TX_PAR   = 3'd3,
    TX_STOP1 = 3'd4,
    TX_STOP2 = 3'd5
  } tx_state_e;

endpackage

// File: rtl/tx_baud_timer.sv
module tx_baud_timer #(
  parameter int OSR = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic tick,
  input  logic half,
  output logic bit_end
);
  localparam int CNT_W = $clog2(OSR);
  localparam logic [CNT_W-1:0] FULL_LAST = CNT_W'(OSR - 1);
  localparam logic [CNT_W-1:0] HALF_LAST = CNT_W'(OSR / 2 - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign bit_end = tick && (cnt_q == (half ? HALF_LAST : FULL_LAST));

  always_comb begin
    cnt_en = clr || tick;
    cnt_d  = cnt_q;
    if (clr || bit_end) cnt_d = '0;
    else if (tick)      cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/tx_shifter.sv
module tx_shifter #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              shift,
  input  logic [DATA_W-1:0] din,
  output logic              lsb
);
  logic [DATA_W-1:0] sh_q, sh_d;
  logic              sh_en;

  always_comb begin
    sh_en = load || shift;
    sh_d  = sh_q;
    if (load)       sh_d = din;
    else if (shift) sh_d = {1'b0, sh_q[DATA_W-1:1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sh_q <= '0;
    else if (sh_en) sh_q <= sh_d;
  end

  assign lsb = sh_q[0];
endmodule

// File: rtl/uart_tx_parity.sv
module uart_tx_parity #(
  parameter int DATA_W  = 8,
  parameter int LEN_W   = 2,
  parameter int MIN_LEN = 5
) (
  input  logic [DATA_W-1:0] data,
  input  logic [LEN_W-1:0]  len,
  input  logic              even,
  output logic              par
);
  logic [DATA_W-1:0] keep;

  for (genvar i = 0; i < DATA_W; i++) begin : g_keep
    if (i < MIN_LEN) begin : g_always
      assign keep[i] = data[i];
    end else begin : g_sel
      assign keep[i] = data[i] && (len >= LEN_W'(i - MIN_LEN + 1));
    end
  end

  assign par = even ? (^keep) : ~(^keep);
endmodule

// File: rtl/uart_frame_tx.sv
module uart_frame_tx #(
  parameter int DATA_W  = 8,
  parameter int LEN_W   = 2,
  parameter int MIN_LEN = 5,
  parameter int OSR     = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              baud_tick,
  input  logic              load,
  input  logic [DATA_W-1:0] tx_data,
  input  logic [LEN_W-1:0]  len_sel,
  input  logic              stop_ext,
  input  logic              par_en,
  input  logic              par_even,
  output logic              txd,
  output logic              busy,
  output logic              ready
);
  import uart_tx_pkg::*;

  localparam int IDX_W = $clog2(DATA_W);

  logic             rs1_q, rs2_q, rst_q_n;
  tx_state_e        state_q, state_d;
  logic [IDX_W-1:0] idx_q, idx_d, last_q;
  logic             par_en_q, par_q, two_stop_q, half_q;
  logic             start_fr, bit_end, shift_en, half_now, sh_lsb, par_calc;

  // reset: asserted at once, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1_q <= 1'b0;
      rs2_q <= 1'b0;
    end else begin
      rs1_q <= 1'b1;
      rs2_q <= rs1_q;
    end
  end
  assign rst_q_n = rs2_q;

  assign start_fr = load && (state_q == TX_IDLE);
  assign half_now = (state_q == TX_STOP2) && half_q;
  assign shift_en = (state_q == TX_DATA) && bit_end;

  tx_baud_timer #(.OSR(OSR)) u_timer (
    .clk(clk), .rst_n(rst_q_n), .clr(start_fr), .tick(baud_tick),
    .half(half_now), .bit_end(bit_end)
  );

  tx_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk(clk), .rst_n(rst_q_n), .load(start_fr), .shift(shift_en),
    .din(tx_data), .lsb(sh_lsb)
  );

  uart_tx_parity #(.DATA_W(DATA_W), .LEN_W(LEN_W), .MIN_LEN(MIN_LEN)) u_par (
    .data(tx_data), .len(len_sel), .even(par_even), .par(par_calc)
  );

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    case (state_q)
      TX_IDLE:  if (start_fr) state_d = TX_START;
      TX_START: if (bit_end) begin
                  state_d = TX_DATA;
                  idx_d   = '0;
                end
      TX_DATA:  if (bit_end) begin
                  if (idx_q == last_q) state_d = par_en_q ? TX_PAR : TX_STOP1;
                  else                 idx_d   = idx_q + 1'b1;
                end
      TX_PAR:   if (bit_end) state_d = TX_STOP1;
      TX_STOP1: if (bit_end) state_d = two_stop_q ? TX_STOP2 : TX_IDLE;
      TX_STOP2: if (bit_end) state_d = TX_IDLE;
      default:  state_d = TX_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      state_q <= TX_IDLE;
      idx_q   <= '0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
    end
  end

  // frame format captured once per frame
  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      last_q     <= '0;
      par_en_q   <= 1'b0;
      par_q      <= 1'b0;
      two_stop_q <= 1'b0;
      half_q     <= 1'b0;
    end else if (start_fr) begin
      last_q     <= IDX_W'(MIN_LEN - 1) + IDX_W'(len_sel);
      par_en_q   <= par_en;
      par_q      <= par_calc;
      two_stop_q <= stop_ext;
      half_q     <= (len_sel == '0);
    end
  end

  always_comb begin
    case (state_q)
      TX_START: txd = 1'b0;
      TX_DATA:  txd = sh_lsb;
      TX_PAR:   txd = par_q;
      default:  txd = 1'b1;
    endcase
  end

  assign busy  = (state_q != TX_IDLE);
  assign ready = (state_q == TX_IDLE);
endmodule

// File: rtl/uart_frame_tx_chk.sv
module uart_frame_tx_chk (
  input logic clk,
  input logic rst_q_n,
  input logic baud_tick,
  input logic load,
  input logic txd,
  input logic busy
);
  // R1
  idle_line_high_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    !busy |-> txd);

  // R2
  load_starts_frame_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (load && !busy) |=> (busy && !txd));

  // R3
  line_moves_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (busy && !baud_tick) |=> $stable(txd));

  // R13
  frame_ends_on_stop_tick_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    $fell(busy) |-> ($past(baud_tick) && $past(txd)));
endmodule

bind uart_frame_tx uart_frame_tx_chk u_chk (
  .clk(clk), .rst_q_n(rst_q_n), .baud_tick(baud_tick),
  .load(load), .txd(txd), .busy(busy)
);

// File: tb/uart_frame_tx_bench.sv
module uart_frame_tx_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       baud_tick = 1'b0;
  logic       load = 1'b0;
  logic [7:0] tx_data = 8'h00;
  logic [1:0] len_sel = 2'b00;
  logic       stop_ext = 1'b0, par_en = 1'b0, par_even = 1'b0;
  logic       txd, busy, ready;

  int compared = 0, mismatched = 0, cycles = 0, tdiv = 0;
  logic  exp_bit [0:11];
  string exp_tag [0:11];
  int    n_ticks;

  uart_frame_tx u_uart_frame_tx (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .load(load),
    .tx_data(tx_data), .len_sel(len_sel), .stop_ext(stop_ext),
    .par_en(par_en), .par_even(par_even), .txd(txd), .busy(busy), .ready(ready)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  always @(negedge clk) begin
    tdiv      = (tdiv == 2) ? 0 : tdiv + 1;
    baud_tick = (tdiv == 2);
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      mismatched++;
      $display("FAIL watchdog: actual %0d cycles expected < %0d", cycles, WATCHDOG);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic act, input logic expv);
    compared++;
    if (act !== expv) begin
      mismatched++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, expv, $time);
    end
  endtask

  // expected frame, computed from the requirements
  task automatic build(input logic [7:0] d, input logic [1:0] ls,
                       input logic se, input logic pe, input logic ev);
    int nb = 5 + int'(ls);
    int k = 0;
    logic ones = 1'b0;
    exp_bit[k] = 1'b0; exp_tag[k] = "R2 start"; k++;
    for (int b = 0; b < nb; b++) begin
      exp_bit[k] = d[b]; exp_tag[k] = "R4/R5 data"; ones ^= d[b]; k++;
    end
    if (pe) begin
      exp_bit[k] = ev ? ones : ~ones; exp_tag[k] = "R6 parity"; k++;
    end
    exp_bit[k] = 1'b1; exp_tag[k] = pe ? "R8 stop" : "R7 stop"; k++;
    n_ticks = 16 * k;
    if (se) begin
      exp_bit[k] = 1'b1;
      exp_tag[k] = (ls == 2'b00) ? "R9 half stop" : "R10 second stop";
      n_ticks += (ls == 2'b00) ? 8 : 16;
    end
  endtask

  task automatic send(input logic [7:0] d, input logic [1:0] ls, input logic se,
                      input logic pe, input logic ev, input bit disturb);
    int i = 0;
    bit poked = 0;
    bit clear_ld = 0;
    build(d, ls, se, pe, ev);
    @(negedge clk);
    tx_data = d; len_sel = ls; stop_ext = se; par_en = pe; par_even = ev;
    load = 1'b1;
    @(negedge clk);
    load = 1'b0;
    #1;
    chk("R2 busy after load", busy, 1'b1);
    chk("R2 ready after load", ready, 1'b0);
    while (i < n_ticks) begin
      if (clear_ld) begin load = 1'b0; clear_ld = 0; end
      if (baud_tick) begin
        chk(exp_tag[i / 16], txd, exp_bit[i / 16]);
        chk("R13 busy in frame", busy, 1'b1);
        i++;
      end
      if (disturb && !poked && i == 20) begin
        // R11 R12: new byte, new format and a load strobe mid-frame
        poked = 1; clear_ld = 1; load = 1'b1;
        tx_data = 8'($urandom); len_sel = 2'($urandom);
        stop_ext = 1'($urandom); par_en = 1'($urandom); par_even = 1'($urandom);
      end
      @(negedge clk);
      #1;
    end
    load = 1'b0;
    chk("R13 busy low after last stop", busy, 1'b0);
    chk("R1 ready after frame", ready, 1'b1);
    chk("R1 line idle after frame", txd, 1'b1);
  endtask

  initial begin
    void'($urandom(32'd2024));
    #(CLK_PERIOD * 3 + 1);
    chk("R1 busy in reset", busy, 1'b0);
    chk("R1 txd in reset", txd, 1'b1);
    chk("R1 ready in reset", ready, 1'b1);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R1 idle txd", txd, 1'b1);
    // every length and stop choice, both parity senses
    for (int l = 0; l < 4; l++)
      for (int s = 0; s < 2; s++) begin
        send(8'hA7, 2'(l), 1'(s), 1'b1, 1'(l % 2), 0);
        send(8'hFF, 2'(l), 1'(s), 1'b0, 1'b0, 0);
      end
    // R5: high bits set beyond a 5-bit length
    send(8'hE0, 2'b00, 1'b0, 1'b1, 1'b1, 0);
    send(8'h00, 2'b11, 1'b1, 1'b1, 1'b0, 0);
    // R11 R12: disturbed frames
    send(8'h35, 2'b00, 1'b1, 1'b1, 1'b0, 1);
    send(8'hC3, 2'b11, 1'b0, 1'b0, 1'b1, 1);
    for (int n = 0; n < 30; n++)
      send(8'($urandom), 2'($urandom), 1'($urandom), 1'($urandom),
           1'($urandom), 1'($urandom));
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule